// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Redirect Flush

This block is the front end of a small in-order 32-bit core built as two stages. The fetch stage owns the program counter and drives it straight out as the instruction memory address. Whatever word memory returns is captured, together with the address it came from, into a single stage register. That register feeds the second stage, which decodes, executes, accesses memory and writes back in one cycle. Because the second stage sees each instruction one cycle after it was fetched, architectural results trail a single-cycle core by one cycle: an instruction fetched in the first cycle after reset executes in the second and its register write becomes visible in the third.

Control hazards are resolved without any prediction. The execute stage reports a taken branch or a jump, with the destination address it computed from the PC carried alongside the instruction. On either report, the fetch PC is loaded with that destination. The word being fetched in the same cycle is on the wrong path, so the fixed no-op word 0x00000013 is muxed into the stage register in its place. A branch that is not taken redirects nothing and squashes nothing. The stage register also comes out of reset holding the no-op, so the first execute cycle has no effect.

Top module: `fe2_frontend`

## Requirements
- R1: A synchronous active-high reset, which dominates every other input, sets the fetch address to 0, the execute instruction to 0x00000013 and the execute PC to 0.
- R2: In a cycle with neither branch-taken nor jump asserted, the fetch address advances by 4 at the next clock edge.
- R3: In a cycle with neither branch-taken nor jump asserted, the word on the memory data input appears on the execute instruction output after the next edge, and the execute PC output shows the fetch address it was read from.
- R4: In a cycle with branch-taken asserted, the fetch address after the next edge equals the redirect target.
- R5: In a cycle with branch-taken asserted, the execute instruction after the next edge is 0x00000013, whatever word memory returned.
- R6: In a cycle with jump asserted, the fetch address is loaded with the target and the next execute instruction is 0x00000013, whether branch-taken is high or low.
- R7: The redirect target has no effect on the fetch address when neither branch-taken nor jump is asserted.
- R8: Redirects in consecutive cycles each take effect: every such cycle loads its own target and inserts another no-op.
- R9: Sequential advance wraps modulo 2^32, so the address after 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch address to instruction memory |
| imem_data | input | 32 | Instruction word read at imem_addr |
| ex_br_taken | input | 1 | Executing branch resolved as taken |
| ex_jump | input | 1 | Executing instruction is a jump |
| ex_target | input | 32 | Redirect destination computed in execute |
| ex_inst | output | 32 | Instruction presented to the execute stage |
| ex_pc | output | 32 | Address the execute instruction was fetched from |

## Verification
The bench aims at the cases where a front end most often goes wrong. It checks that a not-taken branch leaves the fetched word intact; a design that flushes on every branch would show extra no-ops there. It checks that a jump flushes with branch-taken low; a design keyed only on branch-taken would let the wrong-path word execute. A run of back-to-back redirects catches a design that ignores a redirect arriving while a bubble is in execute. A reset applied with a redirect pending, and a sequential step across the top of the address space, catch a reset with the wrong priority and an incrementer with the wrong width.

// File: rtl/fe2_pkg.sv
package fe2_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned INST_W = 32;

    // addi x0, x0, 0: the canonical no-op injected on a flush
    localparam logic [INST_W-1:0] NOP_WORD = 32'h0000_0013;

    typedef enum logic [1:0] {
        RDR_NONE   = 2'd0,
        RDR_BRANCH = 2'd1,
        RDR_JUMP   = 2'd2
    } redir_kind_e;

    typedef struct packed {
        logic [INST_W-1:0] inst;
        logic [ADDR_W-1:0] pc;
    } ex_slot_t;

    function automatic logic [ADDR_W-1:0] fe2_next_pc(
        input logic [ADDR_W-1:0] cur,
        input logic              redirect,
        input logic [ADDR_W-1:0] target,
        input logic [ADDR_W-1:0] step
    );
        return redirect ? target : (cur + step);
    endfunction

endpackage

// File: rtl/fe2_redirect_ctl.sv
module fe2_redirect_ctl
    import fe2_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        br_taken,
    input  logic        jump,
    output redir_kind_e kind,
    output logic        redirect
);

    // a jump takes precedence in classification; both cause a redirect
    always_comb begin
        if (jump)          kind = RDR_JUMP;
        else if (br_taken) kind = RDR_BRANCH;
        else               kind = RDR_NONE;
    end

    assign redirect = (kind != RDR_NONE);

    // R6: jump alone is enough to redirect
    a_r6_jump_redirects: assert property (@(posedge clk) disable iff (rst)
        jump |-> redirect);

    // R7: quiet inputs never redirect
    a_r7_quiet_no_redirect: assert property (@(posedge clk) disable iff (rst)
        (!jump && !br_taken) |-> !redirect);

endmodule

// File: rtl/fe2_pc_gen.sv
module fe2_pc_gen
    import fe2_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC   = '0,
    parameter logic [ADDR_W-1:0] FETCH_STEP = 32'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    logic [ADDR_W-1:0] pc_nxt;

    always_comb pc_nxt = fe2_next_pc(pc, redirect, target, FETCH_STEP);

    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC;
        else     pc <= pc_nxt;
    end

    // R1
    a_r1_pc_reset: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC));

    // R4, R6, R8
    a_r4_pc_takes_target: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (pc == $past(target)));

    // R2, R9
    a_r2_pc_steps: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> (pc == $past(pc) + FETCH_STEP));

endmodule

// File: rtl/fe2_inst_reg.sv
module fe2_inst_reg
    import fe2_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [INST_W-1:0] fetch_word,
    input  logic [ADDR_W-1:0] fetch_pc,
    output ex_slot_t          slot
);

    ex_slot_t slot_nxt;

    always_comb begin
        slot_nxt.pc   = fetch_pc;
        slot_nxt.inst = flush ? NOP_WORD : fetch_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot.inst <= NOP_WORD;
            slot.pc   <= RESET_PC;
        end else begin
            slot <= slot_nxt;
        end
    end

    // R1
    a_r1_slot_reset: assert property (@(posedge clk)
        rst |=> (slot.inst == NOP_WORD && slot.pc == RESET_PC));

    // R5, R6, R8
    a_r5_flush_injects_nop: assert property (@(posedge clk) disable iff (rst)
        flush |=> (slot.inst == NOP_WORD));

    // R3
    a_r3_word_passes: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (slot.inst == $past(fetch_word) && slot.pc == $past(fetch_pc)));

endmodule

// File: rtl/fe2_frontend.sv
module fe2_frontend
    import fe2_pkg::*;
#(
    parameter logic [31:0] RESET_PC   = 32'h0000_0000,
    parameter logic [31:0] FETCH_STEP = 32'd4
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    input  logic        ex_br_taken,
    input  logic        ex_jump,
    input  logic [31:0] ex_target,
    output logic [31:0] ex_inst,
    output logic [31:0] ex_pc
);

    redir_kind_e       kind;
    logic              redirect;
    logic [ADDR_W-1:0] fetch_pc;
    ex_slot_t          slot;

    fe2_redirect_ctl u_rdr (
        .clk      (clk),
        .rst      (rst),
        .br_taken (ex_br_taken),
        .jump     (ex_jump),
        .kind     (kind),
        .redirect (redirect)
    );

    fe2_pc_gen #(
        .RESET_PC   (RESET_PC),
        .FETCH_STEP (FETCH_STEP)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .redirect (redirect),
        .target   (ex_target),
        .pc       (fetch_pc)
    );

    fe2_inst_reg #(
        .RESET_PC (RESET_PC)
    ) u_ir (
        .clk        (clk),
        .rst        (rst),
        .flush      (redirect),
        .fetch_word (imem_data),
        .fetch_pc   (fetch_pc),
        .slot       (slot)
    );

    assign imem_addr = fetch_pc;
    assign ex_inst   = slot.inst;
    assign ex_pc     = slot.pc;

    // R5: a branch-only redirect is classified as a branch and squashes the slot
    a_r5_branch_kind: assert property (@(posedge clk) disable iff (rst)
        (ex_br_taken && !ex_jump) |-> (kind == RDR_BRANCH));

    // R3: a squashed slot still reports the address of the squashed fetch
    a_r3_expc_tracks_fetch: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ex_pc == $past(imem_addr)));

endmodule

// File: tb/sim_fe2_frontend.sv
`timescale 1ns/1ps
module sim_fe2_frontend;

    localparam logic [31:0] NOP = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data = 32'h0;
    logic        ex_br_taken = 1'b0;
    logic        ex_jump = 1'b0;
    logic [31:0] ex_target = 32'h0;
    logic [31:0] ex_inst;
    logic [31:0] ex_pc;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_pc, m_inst, m_expc;

    always #10 clk = ~clk;

    fe2_frontend u0 (
        .clk         (clk),
        .rst         (rst),
        .imem_addr   (imem_addr),
        .imem_data   (imem_data),
        .ex_br_taken (ex_br_taken),
        .ex_jump     (ex_jump),
        .ex_target   (ex_target),
        .ex_inst     (ex_inst),
        .ex_pc       (ex_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_pc(input logic [31:0] cur, input logic bt,
                                             input logic jp, input logic [31:0] tgt);
        return (bt || jp) ? tgt : cur + 32'd4;
    endfunction

    // one cycle: drive at the falling edge, compare at the following falling edge
    task automatic cyc(input logic [31:0] word, input logic bt, input logic jp,
                       input logic [31:0] tgt);
        string ti, tp;
        imem_data = word; ex_br_taken = bt; ex_jump = jp; ex_target = tgt;
        #1;
        check("R2 fetch address", imem_addr, m_pc);
        m_inst = (bt || jp) ? NOP : word;
        m_expc = m_pc;
        m_pc   = model_pc(m_pc, bt, jp, tgt);
        ti = jp ? "R6 inst" : (bt ? "R5 inst" : "R3 inst");
        tp = jp ? "R6 pc"   : (bt ? "R4 pc"   : "R2 pc");
        @(posedge clk); @(negedge clk);
        check(ti, ex_inst, m_inst);
        check("R3 ex_pc", ex_pc, m_expc);
        check(tp, imem_addr, m_pc);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        imem_data = 32'hDEAD_BEEF; ex_br_taken = 1'b1; ex_jump = 1'b1; ex_target = 32'h0000_4000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1 reset addr", imem_addr, 32'h0);
        check("R1 reset inst", ex_inst, NOP);
        check("R1 reset ex_pc", ex_pc, 32'h0);
        rst = 1'b0;
        m_pc = 32'h0; m_inst = NOP; m_expc = 32'h0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R3: plain sequential stream, first fetch reaches execute one cycle later
        for (int i = 0; i < 6; i++) cyc($urandom, 1'b0, 1'b0, $urandom);

        // R5, R4: taken branch squashes the fetched word
        cyc(32'h0000_0063, 1'b1, 1'b0, 32'h0000_0100);
        // R3: not-taken branch keeps the following word
        cyc(32'h1234_5678, 1'b0, 1'b0, 32'h0000_0800);
        // R6: jump with branch-taken low still flushes
        cyc(32'hCAFE_F00D, 1'b0, 1'b1, 32'h0000_0200);
        cyc(32'hCAFE_F00D, 1'b1, 1'b1, 32'h0000_0300);

        // R7: target presented without a redirect has no effect
        a0 = imem_addr;
        cyc(32'h0000_0033, 1'b0, 1'b0, 32'hFFFF_0000);
        check("R7 target ignored", imem_addr, a0 + 32'd4);

        // R8: back-to-back redirects
        cyc(32'h1111_1111, 1'b1, 1'b0, 32'h0000_1000);
        check("R8 first target", imem_addr, 32'h0000_1000);
        cyc(32'h2222_2222, 1'b0, 1'b1, 32'h0000_2000);
        check("R8 second target", imem_addr, 32'h0000_2000);
        check("R8 second nop", ex_inst, NOP);
        cyc(32'h3333_3333, 1'b1, 1'b0, 32'h0000_3000);
        check("R8 third nop", ex_inst, NOP);
        cyc(32'h4444_4444, 1'b0, 1'b0, 32'h0);
        check("R8 stream resumes", ex_inst, 32'h4444_4444);

        // R9: sequential wrap across the top of the address space
        cyc(32'h0, 1'b0, 1'b1, 32'hFFFF_FFF8);
        cyc(32'h5555_5555, 1'b0, 1'b0, 32'h0);
        cyc(32'h6666_6666, 1'b0, 1'b0, 32'h0);
        check("R9 wrap to zero", imem_addr, 32'h0);
        check("R9 last word ex_pc", ex_pc, 32'hFFFF_FFFC);

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc($urandom, r[1:0] == 2'b00, r[3:2] == 2'b00, {$urandom} & 32'hFFFF_FFFC);
        end

        // R1: reset mid-run with a redirect pending
        do_reset();
        cyc(32'h7777_7777, 1'b0, 1'b0, 32'h0);
        check("R1 first fetch after reset", ex_inst, 32'h7777_7777);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule